// File: doc/BRIEF.md
# Watchdog Register Front End with Key-Sequence Unlock

This block sits between a simple memory-mapped bus and a watchdog timer core. It decodes a 16-byte register window holding two timer preload values and a combined reload/status register. Software can only change these protected registers after it writes a two-step key to the reload/status offset. Each unlock is spent on the first word or half-word write that follows.

The block drives the two 20-bit preload values straight to the timer core. It also gives the core a one-cycle reload pulse when software kicks the watchdog, and a one-cycle pulse that clears the core's previous-reboot flag. When software reads the reload/status register, the block returns that flag from the core. The counting logic belongs to the core and is not part of this block.

Bus size codes: 0 = byte, 1 = half-word, 2 = word. Code 3 is handled like a byte. Offsets are 0x0 for the first preload, 0x4 for the second preload and 0xC for reload/status. A write counts as a key when its full 32-bit data value matches the key value.

Top module: `wdt_keyed_regs`

## Requirements
- R1: Reset state. Both preload outputs read 0xFFFFF, both pulses are low, read data is 0, and the unlock sequencer is locked.
- R2: A write of 0x80 to offset 0xC arms the first key step. This works at any size and from any unlock state.
- R3: A write of 0x86 to offset 0xC completes the unlock only when the first step is armed. From the locked or open state, 0x86 does not unlock.
- R4: When unlocked, a word write to offset 0x0 loads the first preload with the low 20 bits of the data. A word write to offset 0x4 loads the second preload the same way. The new value appears the cycle after the write.
- R5: When unlocked, a half-word write to offset 0xC has these effects the cycle after the write: data bit 8 raises the reload pulse, and data bit 9 or bit 12 raises the flag-clear pulse.
- R6: Any non-key word or half-word write made while unlocked locks the sequencer again, whatever its address. A second protected write then has no effect.
- R7: A non-key byte write never changes a preload or raises a pulse, and it leaves the unlock state unchanged.
- R8: Non-key writes made while locked, or with only the first key step armed, have no effect on the outputs.
- R9: A half-word read at offset 0xC returns 0x1200 when the previous-reboot flag input is high, and 0 when it is low. Every other read returns 0. The read value appears the cycle after the read strobe.
- R10: The reload and flag-clear outputs are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Byte offset in the window |
| busWdata | input | 32 | Write data |
| busSize | input | 2 | Access size: 0 byte, 1 half, 2 word |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| rebootFlag | input | 1 | Previous-reboot flag from the core |
| rdData | output | 32 | Registered read data |
| preloadOne | output | 20 | First-stage preload |
| preloadTwo | output | 20 | Second-stage preload |
| reloadPulse | output | 1 | Watchdog kick pulse |
| flagClearPulse | output | 1 | Pulse clearing the reboot flag |

## Verification
Every result comes one register stage after the bus strobe: the preload outputs, both pulses and the read data all change on the edge that samples the write or read. The bench drives each access on the falling edge and samples one nanosecond after the next rising edge, where that result is due. For the pulses it samples again one cycle later to confirm they have dropped. To check that a write was ignored, the bench reads the preload outputs or watches the pulse outputs in the cycle the write would have acted. To observe the unlock state, it follows the stimulus with a protected write and checks whether that write takes effect.

// File: rtl/wdtk_pkg.sv
package wdtk_pkg;
  typedef enum logic [1:0] {
    LOCKED = 2'd0,
    ARMED  = 2'd1,
    OPEN   = 2'd2
  } unlockState_t;

  typedef struct packed {
    logic loadOne;
    logic loadTwo;
    logic reload;
    logic clearFlag;
    logic readHit;
  } regStrobes_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/wdtk_ctrl.sv
module wdtk_ctrl
  import wdtk_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int KEY_FIRST   = 'h80,
  parameter int KEY_SECOND  = 'h86,
  parameter int OFF_ONE     = 'h0,
  parameter int OFF_TWO     = 'h4,
  parameter int OFF_KICK    = 'hC,
  parameter int KICK_BIT    = 8,
  parameter int CLEAR_BIT_A = 9,
  parameter int CLEAR_BIT_B = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [1:0]        busSize,
  input  logic              busWr,
  input  logic              busRd,
  output regStrobes_t       strobes
);
  localparam logic [ADDR_W-1:0] ADDR_ONE  = ADDR_W'(OFF_ONE);
  localparam logic [ADDR_W-1:0] ADDR_TWO  = ADDR_W'(OFF_TWO);
  localparam logic [ADDR_W-1:0] ADDR_KICK = ADDR_W'(OFF_KICK);
  localparam logic [DATA_W-1:0] KEY_A     = DATA_W'(KEY_FIRST);
  localparam logic [DATA_W-1:0] KEY_B     = DATA_W'(KEY_SECOND);

  unlockState_t state, stateNext;
  logic keyA, keyB, wideWr, protWr;

  always_comb begin
    keyA   = busWr && (busAddr == ADDR_KICK) && (busWdata == KEY_A);
    keyB   = busWr && (busAddr == ADDR_KICK) && (busWdata == KEY_B) && (state == ARMED);
    wideWr = busWr && ((busSize == SZ_HALF) || (busSize == SZ_WORD));
    protWr = wideWr && !keyA && !keyB && (state == OPEN);

    strobes.loadOne   = protWr && (busSize == SZ_WORD) && (busAddr == ADDR_ONE);
    strobes.loadTwo   = protWr && (busSize == SZ_WORD) && (busAddr == ADDR_TWO);
    strobes.reload    = protWr && (busSize == SZ_HALF) && (busAddr == ADDR_KICK)
                        && busWdata[KICK_BIT];
    strobes.clearFlag = protWr && (busSize == SZ_HALF) && (busAddr == ADDR_KICK)
                        && (busWdata[CLEAR_BIT_A] || busWdata[CLEAR_BIT_B]);
    strobes.readHit   = busRd && (busSize == SZ_HALF) && (busAddr == ADDR_KICK);

    stateNext = state;
    if (keyA)        stateNext = ARMED;
    else if (keyB)   stateNext = OPEN;
    else if (protWr) stateNext = LOCKED;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= LOCKED;
    else       state <= stateNext;
  end
endmodule

// File: rtl/wdtk_dpath.sv
module wdtk_dpath
  import wdtk_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int PRE_W       = 20,
  parameter int CLEAR_BIT_A = 9,
  parameter int CLEAR_BIT_B = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              rebootFlag,
  input  regStrobes_t       strobes,
  output logic [DATA_W-1:0] rdData,
  output logic [PRE_W-1:0]  preloadOne,
  output logic [PRE_W-1:0]  preloadTwo,
  output logic              reloadPulse,
  output logic              flagClearPulse
);
  localparam logic [PRE_W-1:0]  PRE_RESET = '1;
  localparam logic [DATA_W-1:0] FLAG_WORD =
    (DATA_W'(1) << CLEAR_BIT_A) | (DATA_W'(1) << CLEAR_BIT_B);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preloadOne     <= PRE_RESET;
      preloadTwo     <= PRE_RESET;
      reloadPulse    <= 1'b0;
      flagClearPulse <= 1'b0;
      rdData         <= '0;
    end else begin
      if (strobes.loadOne) preloadOne <= busWdata[PRE_W-1:0];
      if (strobes.loadTwo) preloadTwo <= busWdata[PRE_W-1:0];
      reloadPulse    <= strobes.reload;
      flagClearPulse <= strobes.clearFlag;
      rdData         <= (strobes.readHit && rebootFlag) ? FLAG_WORD : '0;
    end
  end
endmodule

// File: rtl/wdt_keyed_regs.sv
module wdt_keyed_regs
  import wdtk_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [1:0]        busSize,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              rebootFlag,
  output logic [DATA_W-1:0] rdData,
  output logic [PRE_W-1:0]  preloadOne,
  output logic [PRE_W-1:0]  preloadTwo,
  output logic              reloadPulse,
  output logic              flagClearPulse
);
  regStrobes_t strobes;

  wdtk_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busSize(busSize), .busWr(busWr), .busRd(busRd), .strobes(strobes)
  );

  wdtk_dpath #(.DATA_W(DATA_W), .PRE_W(PRE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .busWdata(busWdata), .rebootFlag(rebootFlag),
    .strobes(strobes), .rdData(rdData), .preloadOne(preloadOne),
    .preloadTwo(preloadTwo), .reloadPulse(reloadPulse),
    .flagClearPulse(flagClearPulse)
  );
endmodule

// File: rtl/wdtk_checker.sv
module wdtk_checker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        busSize,
  input logic              busWr,
  input logic              busRd,
  input logic              rebootFlag,
  input logic [DATA_W-1:0] rdData,
  input logic [PRE_W-1:0]  preloadOne,
  input logic [PRE_W-1:0]  preloadTwo,
  input logic              reloadPulse,
  input logic              flagClearPulse
);
  localparam logic [ADDR_W-1:0] A_ONE  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_TWO  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_KICK = ADDR_W'(12);

  // R10: single-cycle pulses
  a_r10_reload_single: assert property (@(posedge clk) disable iff (!rstN)
    reloadPulse |=> !reloadPulse);
  a_r10_clear_single: assert property (@(posedge clk) disable iff (!rstN)
    flagClearPulse |=> !flagClearPulse);

  // R4: preload changes only after a word write to its offset
  a_r4_one_source: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(preloadOne) |-> $past(busWr && busSize == 2'd2 && busAddr == A_ONE));
  a_r4_two_source: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(preloadTwo) |-> $past(busWr && busSize == 2'd2 && busAddr == A_TWO));

  // R5 / R7: pulses only follow a half-word write to the kick offset
  a_r5_reload_source: assert property (@(posedge clk) disable iff (!rstN)
    reloadPulse |-> $past(busWr && busSize == 2'd1 && busAddr == A_KICK));
  a_r7_clear_not_byte: assert property (@(posedge clk) disable iff (!rstN)
    flagClearPulse |-> $past(busWr && busSize == 2'd1 && busAddr == A_KICK));

  // R9: non-zero read data only after a flagged half read at the kick offset
  a_r9_read_source: assert property (@(posedge clk) disable iff (!rstN)
    (rdData != '0) |-> $past(busRd && busSize == 2'd1 && busAddr == A_KICK && rebootFlag));
endmodule

bind wdt_keyed_regs wdtk_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_W(PRE_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busSize(busSize), .busWr(busWr),
  .busRd(busRd), .rebootFlag(rebootFlag), .rdData(rdData), .preloadOne(preloadOne),
  .preloadTwo(preloadTwo), .reloadPulse(reloadPulse), .flagClearPulse(flagClearPulse)
);

// File: tb/wdt_keyed_regs_bench.sv
module wdt_keyed_regs_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [1:0]  busSize = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic        rebootFlag = 1'b0;
  logic [31:0] rdData;
  logic [19:0] preloadOne, preloadTwo;
  logic        reloadPulse, flagClearPulse;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdt_keyed_regs u_wdt_keyed_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busSize(busSize), .busWr(busWr), .busRd(busRd), .rebootFlag(rebootFlag),
    .rdData(rdData), .preloadOne(preloadOne), .preloadTwo(preloadTwo),
    .reloadPulse(reloadPulse), .flagClearPulse(flagClearPulse)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // write: drive on falling edge, results sampled 1 ns after the rising edge
  task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busSize = sz; busWdata = d; busWr = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] sz, output logic [31:0] v);
    @(negedge clk);
    busAddr = a; busSize = sz; busRd = 1'b1;
    @(posedge clk); #1;
    busRd = 1'b0;
    v = rdData;
  endtask

  task automatic unlock();
    wr(4'hC, 2'd1, 32'h80);
    wr(4'hC, 2'd1, 32'h86);
  endtask

  task automatic t_reset();
    check("R1 preloadOne", 32'(preloadOne), 32'hFFFFF);
    check("R1 preloadTwo", 32'(preloadTwo), 32'hFFFFF);
    check("R1 pulses", {30'd0, reloadPulse, flagClearPulse}, 32'd0);
    check("R1 rdData", rdData, 32'd0);
    wr(4'h0, 2'd2, 32'h12345);
    check("R1 locked after reset", 32'(preloadOne), 32'hFFFFF);
  endtask

  task automatic t_load();
    unlock();
    wr(4'h0, 2'd2, 32'hABCDE123);
    check("R4 preloadOne masked", 32'(preloadOne), 32'hDE123);
    unlock();
    wr(4'h4, 2'd2, 32'hFFF00001);
    check("R4 preloadTwo masked", 32'(preloadTwo), 32'h00001);
    check("R4 preloadOne kept", 32'(preloadOne), 32'hDE123);
  endtask

  task automatic t_kick();
    unlock();
    wr(4'hC, 2'd1, 32'h100);
    check("R5 reload on bit8", {31'd0, reloadPulse}, 32'd1);
    check("R5 no clear on bit8", {31'd0, flagClearPulse}, 32'd0);
    @(posedge clk); #1;
    check("R10 reload drops", {31'd0, reloadPulse}, 32'd0);
    unlock();
    wr(4'hC, 2'd1, 32'h200);
    check("R5 clear on bit9", {30'd0, reloadPulse, flagClearPulse}, 32'd1);
    @(posedge clk); #1;
    check("R10 clear drops", {31'd0, flagClearPulse}, 32'd0);
    unlock();
    wr(4'hC, 2'd1, 32'h1100);
    check("R5 both on bits 8,12", {30'd0, reloadPulse, flagClearPulse}, 32'd3);
  endtask

  task automatic t_consumed();
    unlock();
    wr(4'h0, 2'd1, 32'h0);
    wr(4'h0, 2'd2, 32'h5);
    check("R6 unlock spent by half write", 32'(preloadOne), 32'hDE123);
    unlock();
    wr(4'h8, 2'd2, 32'h0);
    wr(4'hC, 2'd1, 32'h100);
    check("R6 unlock spent by other address", {31'd0, reloadPulse}, 32'd0);
  endtask

  task automatic t_keys();
    wr(4'hC, 2'd1, 32'h86);
    wr(4'h4, 2'd2, 32'h777);
    check("R3 second key alone", 32'(preloadTwo), 32'h00001);
    wr(4'hC, 2'd0, 32'h80);
    wr(4'hC, 2'd1, 32'h80);
    wr(4'hC, 2'd2, 32'h86);
    wr(4'h4, 2'd2, 32'h777);
    check("R2 first key at byte and repeated", 32'(preloadTwo), 32'h777);
    unlock();
    wr(4'hC, 2'd1, 32'h86);
    wr(4'h4, 2'd2, 32'h999);
    check("R3 second key while open relocks", 32'(preloadTwo), 32'h777);
  endtask

  task automatic t_byte();
    unlock();
    wr(4'h0, 2'd0, 32'h33);
    check("R7 byte write no load", 32'(preloadOne), 32'hDE123);
    wr(4'hC, 2'd0, 32'h1300);
    check("R7 byte write no pulse", {30'd0, reloadPulse, flagClearPulse}, 32'd0);
    wr(4'h0, 2'd2, 32'h4242);
    check("R7 state kept across byte", 32'(preloadOne), 32'h4242);
  endtask

  task automatic t_armed();
    wr(4'hC, 2'd1, 32'h80);
    wr(4'h0, 2'd2, 32'h1);
    check("R8 write while armed", 32'(preloadOne), 32'h4242);
    wr(4'hC, 2'd1, 32'h1300);
    check("R8 kick while locked", {30'd0, reloadPulse, flagClearPulse}, 32'd0);
  endtask

  task automatic t_read();
    logic [31:0] v;
    rebootFlag = 1'b0;
    rd(4'hC, 2'd1, v);
    check("R9 flag low", v, 32'h0);
    rebootFlag = 1'b1;
    rd(4'hC, 2'd1, v);
    check("R9 flag high", v, 32'h1200);
    rd(4'hC, 2'd2, v);
    check("R9 word read", v, 32'h0);
    rd(4'h0, 2'd1, v);
    check("R9 other offset", v, 32'h0);
    rebootFlag = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_load();
    t_kick();
    t_consumed();
    t_keys();
    t_byte();
    t_armed();
    t_read();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule